// File: doc/BRIEF.md
# Interrupt Combiner with Re-Assert Gap

This block merges six sticky interrupt flags into one active-low request line for a host. Each flag is set by a one-cycle event from its source, and it stays set until the host writes a one to its clear strobe. An 8-bit enable mask decides which flags may drive the line. The bit order of the flags, from bit 0 upward, is: key event, general-purpose input, logic 1, logic 2, event overflow, lock. Mask bits 7 and 6 have no function.

A mode bit sets what the line does when the host clears one enabled flag while other enabled flags remain set. In level mode the line stays low. In pulse mode the line releases for a fixed gap and then goes low again. The host samples the line on an edge, and this second falling edge tells it that more work is waiting. The gap is about 50 µs. Its length in cycles comes from the clock-frequency and gap-length parameters. The default is 5000 cycles at 100 MHz.

Top module: `irq_combiner`

## Requirements
- R1: While reset is held, and in the first cycle after it, all flags read 0 and `irq_n` is 1.
- R2: A 1 on `src_evt[i]` sets `flags[i]` at the next clock edge. The flag stays set after the event goes away, until it is cleared.
- R3: A 1 on `clr_w1c[i]` clears `flags[i]` at the next clock edge. It does not change any other flag.
- R4: If `src_evt[i]` and `clr_w1c[i]` are both 1 in the same cycle, `flags[i]` is 1 after the edge.
- R5: When no gap is running, `irq_n` is 0 exactly when some flag `i` is set and `irq_mask[i]` is 1. Flags that are not enabled never pull the line low. Mask bits 7 and 6 have no effect.
- R6: With `pulse_mode` = 0, clearing one enabled flag while another enabled flag stays set leaves `irq_n` at 0.
- R7: With `pulse_mode` = 1, clearing one enabled flag while another enabled flag stays set drives `irq_n` to 1 for exactly GAP_CYCLES cycles after the clearing edge. After that the line returns to 0.
- R8: When a clear leaves no enabled flag set, `irq_n` goes to 1 at that edge and no re-assert follows.
- R9: In pulse mode, clearing a flag that is not enabled starts no gap, and `irq_n` stays 0 while enabled flags remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 6 | One-cycle set events, one bit per source |
| clr_w1c | input | 6 | Write-one-to-clear strobes, one bit per flag |
| irq_mask | input | 8 | Enable mask; bits 5:0 are used |
| pulse_mode | input | 1 | 0 = level mode, 1 = release-and-reassert mode |
| irq_n | output | 1 | Active-low interrupt line |
| flags | output | 6 | Sticky status flags |

## Verification
The level-mode assertion assumes that `pulse_mode` does not change while a gap is running. A gap started in pulse mode would otherwise still hold the line high after a switch to level mode. The stimulus sets the mode only when all flags are clear, and it waits for every gap to end before the next scenario. The mask also changes only between scenarios, so a gap is never started under one mask and observed under another.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int CLK_HZ = 100_000_000,
  parameter int GAP_US = 50,
  parameter int NSRC   = 6,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   clr_w1c,
  input  logic [MASK_W-1:0] irq_mask,
  input  logic              pulse_mode,
  output logic              irq_n,
  output logic [NSRC-1:0]   flags
);
  localparam int GAP_CYCLES = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int CNT_W      = $clog2(GAP_CYCLES + 1);

  logic [CNT_W-1:0] gap_cnt;
  logic [NSRC-1:0]  en, flags_nxt, dropped;
  logic             active, act_nxt, gap_busy;
  wire              unused_mask = ^irq_mask[MASK_W-1:NSRC];

  assign en        = irq_mask[NSRC-1:0];
  assign flags_nxt = (flags & ~clr_w1c) | src_evt;
  assign dropped   = flags & en & clr_w1c & ~src_evt;
  assign act_nxt   = |(flags_nxt & en);
  assign active    = |(flags & en);
  assign gap_busy  = gap_cnt != '0;
  assign irq_n     = ~(active && !gap_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      gap_cnt <= '0;
    end else begin
      flags <= flags_nxt;
      if (!act_nxt)
        gap_cnt <= '0;
      else if (pulse_mode && |dropped)
        gap_cnt <= CNT_W'(GAP_CYCLES);
      else if (gap_busy)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |src_evt |=> ((flags & $past(src_evt)) == $past(src_evt)));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |(src_evt & clr_w1c) |=> ((flags & $past(src_evt & clr_w1c)) == $past(src_evt & clr_w1c)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags & ~clr_w1c) & ~flags) == '0));

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> irq_n);

  assert_level_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && active) |-> !irq_n);

  assert_gap_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_busy) |-> irq_n);

  assert_gap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= CNT_W'(GAP_CYCLES));

  assert_no_gap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !gap_busy);
endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;
  localparam int GAP = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_evt = '0, clr_w1c = '0;
  logic [7:0] irq_mask = '0;
  logic       pulse_mode = 1'b0;
  logic       irq_n;
  logic [5:0] flags;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  irq_combiner dut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .clr_w1c(clr_w1c),
    .irq_mask(irq_mask), .pulse_mode(pulse_mode), .irq_n(irq_n), .flags(flags));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] e, input logic [5:0] c);
    src_evt = e; clr_w1c = c;
    @(negedge clk);
    src_evt = '0; clr_w1c = '0;
  endtask

  task automatic wipe();
    drive(6'h00, 6'h3f);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(flags == 6'h0, "R1 flags", flags, 0);
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flags == 6'h0 && irq_n, "R1 after release", {irq_n, flags}, 8'h40);
  endtask

  task automatic t_sticky();
    irq_mask = 8'h3f; pulse_mode = 1'b0;
    drive(6'h05, 6'h00);
    chk(flags == 6'h05, "R2 set", flags, 6'h05);
    repeat (3) @(negedge clk);
    chk(flags == 6'h05, "R2 sticky", flags, 6'h05);
    chk(irq_n == 1'b0, "R5 enabled low", irq_n, 0);
    wipe();
  endtask

  task automatic t_w1c();
    drive(6'h3f, 6'h00);
    drive(6'h00, 6'h12);
    chk(flags == 6'h2d, "R3 w1c", flags, 6'h2d);
    wipe();
    chk(flags == 6'h00, "R3 clear all", flags, 0);
  endtask

  task automatic t_collision();
    drive(6'h08, 6'h00);
    drive(6'h08, 6'h08);
    chk(flags == 6'h08, "R4 set wins held", flags, 6'h08);
    wipe();
    drive(6'h20, 6'h20);
    chk(flags == 6'h20, "R4 set wins fresh", flags, 6'h20);
    wipe();
  endtask

  task automatic t_mask();
    irq_mask = 8'hc0;
    drive(6'h3f, 6'h00);
    chk(irq_n == 1'b1, "R5 upper mask bits ignored", irq_n, 1);
    irq_mask = 8'h10;
    @(negedge clk);
    chk(irq_n == 1'b0, "R5 overflow bit enabled", irq_n, 0);
    drive(6'h00, 6'h10);
    chk(irq_n == 1'b1, "R5 only disabled flags", irq_n, 1);
    wipe();
    irq_mask = 8'h3f;
  endtask

  task automatic t_level();
    pulse_mode = 1'b0;
    drive(6'h03, 6'h00);
    drive(6'h00, 6'h01);
    chk(irq_n == 1'b0, "R6 stays low", irq_n, 0);
    repeat (10) @(negedge clk);
    chk(irq_n == 1'b0, "R6 still low", irq_n, 0);
    wipe();
  endtask

  task automatic t_pulse();
    int hi = 0;
    pulse_mode = 1'b1;
    drive(6'h0c, 6'h00);
    chk(irq_n == 1'b0, "R7 low before", irq_n, 0);
    drive(6'h00, 6'h04);
    for (int i = 0; i < GAP + 5 && irq_n; i++) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == GAP, "R7 gap length", hi, GAP);
    chk(irq_n == 1'b0, "R7 reasserted", irq_n, 0);
    wipe();
  endtask

  task automatic t_clear_all();
    int lows = 0;
    pulse_mode = 1'b1;
    drive(6'h30, 6'h00);
    drive(6'h00, 6'h30);
    chk(irq_n == 1'b1, "R8 immediate release", irq_n, 1);
    for (int i = 0; i < GAP + 10; i++) begin
      if (!irq_n) lows++;
      @(negedge clk);
    end
    chk(lows == 0, "R8 no reassert", lows, 0);
  endtask

  task automatic t_disabled_clear();
    pulse_mode = 1'b1; irq_mask = 8'h01;
    drive(6'h03, 6'h00);
    drive(6'h00, 6'h02);
    chk(irq_n == 1'b0, "R9 no gap", irq_n, 0);
    chk(flags == 6'h01, "R9 flags", flags, 6'h01);
    wipe();
    irq_mask = 8'h3f;
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_w1c();
    t_collision();
    t_mask();
    t_level();
    t_pulse();
    t_clear_all();
    t_disabled_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule